// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker traverses a chain of command nodes stored in a word-organised memory and forwards their contents to a downstream command port. Each node is one header word followed by zero or more payload words. A start pulse carries the byte address of the first node. The walker fetches each header and sends that node's payload words in order on the command port. It then follows the header's link to the next node. It stops at a terminating link, or at a link that shows the node has been seen already.

A chain can link back on itself. To find this, the walker writes a visited tag (bit 23) into every header it reads. When a link comes back carrying that tag, the walk ends. A second pass then starts again at the start address and visits the same number of nodes, removing the tags. At the end a single done pulse is raised. The total number of words moved (one header plus the payload of each node visited) is held on an output until the next start.

Memory is reached through one read/write port with a read latency of one cycle. The command port is a plain valid/data pair with no backpressure.

Top module: `chain_walker`

## Requirements
- R1: A header holds the payload word count in bits 31:24 and the byte link to the next node in bits 23:0. The payload words sit at the word indices directly after the header, and they are presented on `cmd_data` with `cmd_valid` high, once each, in ascending address order.
- R2: Each node stops the walk after it when its link has bit 23 set. This covers the terminator 0xFFFFFF. A start address equal to 0xFFFFFF visits no node and gives a total of 0.
- R3: Byte addresses (start and links) are masked to 21 bits. The memory word index is bits 20:2, so address bits 23:21 do not change which word is accessed.
- R4: In the cycle after a header is read, the same word is written back with bit 23 set and all other bits unchanged.
- R5: A chain that links back to a node it has already visited processes that node (header and payload) a second time and then stops.
- R6: A node with a payload count of zero puts nothing on the command port, and the walk goes on to its link.
- R7: After the walk, a cleanup pass starts from the start address, follows the links, and clears bit 23 in exactly as many headers as the walk visited. In memory, only those header words are changed.
- R8: `total_words` equals the sum, over every node visit, of 1 plus that node's payload count.
- R9: `done` is high for exactly one cycle once cleanup has finished, and `busy` falls together with it. `total_words` keeps its value until the next accepted start.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a walk when idle |
| start_addr | input | 24 | Byte address of the first node |
| mem_addr | output | 19 | Memory word index |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| cmd_valid | output | 1 | Payload word present on `cmd_data` |
| cmd_data | output | 32 | Payload word |
| busy | output | 1 | Walk or cleanup in progress |
| done | output | 1 | One-cycle completion pulse |
| total_words | output | 32 | Words moved by the last walk |

## Verification
The hardest situations to reach are the loop cases. There, the tag written back by R4 is what the walker later reads, so the walk length and cleanup count depend on the design's own earlier writes. The bench builds chains whose last link points to the first node, and whose single node links to itself. It also builds a node whose link carries bit 23 before the walk starts, so cleanup removes a bit the walk never set. It then compares the whole memory image, the payload stream and the order of tag-set and tag-clear writes against a behavioural walk of its own copy of the memory.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_HREQ,
    S_HWAIT,
    S_PREQ,
    S_PWAIT,
    S_CREQ,
    S_CWAIT,
    S_DONE
  } cw_state_e;
endpackage

// File: rtl/cw_tally.sv
module cw_tally #(
  parameter int LEN_W = 8,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [LEN_W-1:0] len,
  output logic [TOT_W-1:0] total
);
  function automatic logic [TOT_W-1:0] node_words(input logic [LEN_W-1:0] n);
    return TOT_W'(n) + TOT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   total <= '0;
    else if (clr) total <= '0;
    else if (add) total <= total + node_words(len);
  end
endmodule

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int LINK_W   = 24,
  parameter int MARK_BIT = 23,
  parameter int NODE_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LINK_W-1:0]   start_addr,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                cmd_valid,
  output logic [DATA_W-1:0]   cmd_data,
  output logic                busy,
  output logic                done,
  output logic                walk_clr,
  output logic                hdr_beat,
  output logic [LEN_W-1:0]    hdr_len
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [LINK_W-1:0] TERM = {LINK_W{1'b1}};

  function automatic logic [LEN_W-1:0] hdr_count(input logic [DATA_W-1:0] h);
    return h[DATA_W-1 -: LEN_W];
  endfunction
  function automatic logic [LINK_W-1:0] hdr_link(input logic [DATA_W-1:0] h);
    return h[LINK_W-1:0];
  endfunction
  function automatic logic link_stops(input logic [LINK_W-1:0] l);
    return l[MARK_BIT];
  endfunction
  function automatic logic [WIDX_W-1:0] widx_of(input logic [LINK_W-1:0] l);
    return l[ADDR_W-1:2];
  endfunction
  function automatic logic [DATA_W-1:0] put_mark(input logic [DATA_W-1:0] h, input logic v);
    logic [DATA_W-1:0] r;
    r = h;
    r[MARK_BIT] = v;
    return r;
  endfunction

  cw_state_e          state;
  logic [LINK_W-1:0]  cur, start_q, nxt_q;
  logic               stop_q;
  logic [WIDX_W-1:0]  pidx;
  logic [LEN_W-1:0]   rem;
  logic [NODE_W-1:0]  nodes, cdone;

  logic        pay_beat, clean_beat, walk_stop, pay_last;
  logic [LINK_W-1:0] rd_link;

  assign hdr_beat   = (state == S_HWAIT);
  assign pay_beat   = (state == S_PWAIT);
  assign clean_beat = (state == S_CWAIT);
  assign hdr_len    = hdr_count(mem_rdata);
  assign rd_link    = hdr_link(mem_rdata);
  assign walk_stop  = link_stops(rd_link);
  assign pay_last   = (rem == LEN_W'(1));
  assign walk_clr   = (state == S_IDLE) && start;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign cmd_valid  = pay_beat;
  assign cmd_data   = pay_beat ? mem_rdata : '0;

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    mem_addr  = widx_of(cur);
    case (state)
      S_HREQ:  mem_rd = 1'b1;
      S_HWAIT: begin mem_wr = 1'b1; mem_wdata = put_mark(mem_rdata, 1'b1); end
      S_PREQ:  begin mem_rd = 1'b1; mem_addr = pidx; end
      S_CREQ:  mem_rd = 1'b1;
      S_CWAIT: begin mem_wr = 1'b1; mem_wdata = put_mark(mem_rdata, 1'b0); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      start_q <= '0;
      nxt_q   <= '0;
      stop_q  <= 1'b0;
      pidx    <= '0;
      rem     <= '0;
      nodes   <= '0;
      cdone   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur     <= start_addr;
          start_q <= start_addr;
          nodes   <= '0;
          state   <= (start_addr == TERM) ? S_DONE : S_HREQ;
        end
        S_HREQ: state <= S_HWAIT;
        S_HWAIT: begin
          nxt_q  <= rd_link;
          stop_q <= walk_stop;
          nodes  <= nodes + NODE_W'(1);
          pidx   <= widx_of(cur) + WIDX_W'(1);
          rem    <= hdr_len;
          if (hdr_len != '0) begin
            state <= S_PREQ;
          end else if (walk_stop) begin
            cur   <= start_q;
            cdone <= '0;
            state <= S_CREQ;
          end else begin
            cur   <= rd_link;
            state <= S_HREQ;
          end
        end
        S_PREQ: state <= S_PWAIT;
        S_PWAIT: begin
          pidx <= pidx + WIDX_W'(1);
          rem  <= rem - LEN_W'(1);
          if (!pay_last) begin
            state <= S_PREQ;
          end else if (stop_q) begin
            cur   <= start_q;
            cdone <= '0;
            state <= S_CREQ;
          end else begin
            cur   <= nxt_q;
            state <= S_HREQ;
          end
        end
        S_CREQ: state <= S_CWAIT;
        S_CWAIT: begin
          cur   <= rd_link;
          cdone <= cdone + NODE_W'(1);
          state <= (cdone + NODE_W'(1) == nodes) ? S_DONE : S_CREQ;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: one memory access per cycle
  a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R4: every write lands on the word read the cycle before
  a_r4_write_back: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));
  // R6: an empty node is followed by no payload beat
  a_r6_empty_node: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_beat && hdr_len == '0) |=> !cmd_valid);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: payload only flows during a walk
  a_r1_cmd_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy && !clean_beat);
endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int LINK_W   = 24,
  parameter int MARK_BIT = 23,
  parameter int NODE_W   = 24,
  parameter int TOT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINK_W-1:0] start_addr,
  output logic [ADDR_W-3:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic [TOT_W-1:0]  total_words
);
  logic             walk_clr, hdr_beat;
  logic [LEN_W-1:0] hdr_len;

  cw_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .LINK_W(LINK_W), .MARK_BIT(MARK_BIT), .NODE_W(NODE_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(busy), .done(done), .walk_clr(walk_clr),
    .hdr_beat(hdr_beat), .hdr_len(hdr_len)
  );

  cw_tally #(.LEN_W(LEN_W), .TOT_W(TOT_W)) tally_i (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .add(hdr_beat),
    .len(hdr_len), .total(total_words)
  );

  // R9: the total stays put while idle and no start arrives
  a_r9_total_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(total_words));
endmodule

// File: tb/chain_walker_tb_top.sv
module chain_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic [18:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        busy, done;
  logic [31:0] total_words;

  always #10 clk = ~clk;

  chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(busy), .done(done), .total_words(total_words)
  );

  logic [31:0] ram [0:1023];
  logic [31:0] gm  [0:1023];
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  bit          wr_q[$];
  int          exp_total, exp_n;
  int          checks = 0, fails = 0;
  logic        capture = 1'b0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram[mem_addr[9:0]];
    if (mem_wr) ram[mem_addr[9:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (capture && cmd_valid) got_q.push_back(cmd_data);
    if (capture && mem_wr)    wr_q.push_back(mem_wdata[23]);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int widx(input logic [23:0] a);
    return int'(a[11:2]);
  endfunction

  task automatic fill_bg();
    for (int i = 0; i < 1024; i++) ram[i] = {8'h3C, 8'(i * 5), 16'(i)};
  endtask

  task automatic set_hdr(input int w, input int len, input logic [23:0] link);
    ram[w] = {len[7:0], link};
  endtask

  // behavioural walk on a copy of memory
  task automatic model(input logic [23:0] sa);
    logic [23:0] a, nx;
    int idx, len;
    for (int i = 0; i < 1024; i++) gm[i] = ram[i];
    exp_q.delete();
    exp_total = 0;
    exp_n = 0;
    if (sa == 24'hFFFFFF) return;
    a = sa;
    while (exp_n < 2000) begin
      idx = widx(a);
      len = int'(gm[idx][31:24]);
      nx  = gm[idx][23:0];
      gm[idx] = gm[idx] | 32'h0080_0000;
      exp_total += 1 + len;
      for (int k = 0; k < len; k++) exp_q.push_back(gm[(idx + 1 + k) % 1024]);
      exp_n++;
      if (nx[23]) break;
      a = nx;
    end
    a = sa;
    for (int n = 0; n < exp_n; n++) begin
      idx = widx(a);
      a = gm[idx][23:0];
      gm[idx] = gm[idx] & ~32'h0080_0000;
    end
  endtask

  task automatic run(input logic [23:0] sa, input bit inject, input string tag);
    int cyc;
    bit ok;
    int bad;
    model(sa);
    got_q.delete();
    wr_q.delete();
    capture = 1'b1;
    @(negedge clk);
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0; start_addr = 24'h0;
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1'b1; start_addr = 24'h000040;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9", {tag, " done seen"}, cyc, 0);
    chk(total_words == 32'(exp_total), "R8", {tag, " total"}, total_words, exp_total);
    ok = (got_q.size() == exp_q.size());
    for (int i = 0; ok && i < exp_q.size(); i++) ok = (got_q[i] == exp_q[i]);
    chk(ok, "R1", {tag, " payload stream length"}, got_q.size(), exp_q.size());
    bad = 0;
    for (int i = 0; i < 1024; i++) if (ram[i] !== gm[i]) bad++;
    chk(bad == 0, "R7", {tag, " memory words differing"}, bad, 0);
    ok = (wr_q.size() == 2 * exp_n);
    for (int i = 0; ok && i < wr_q.size(); i++) ok = (wr_q[i] == (i < exp_n));
    chk(ok, "R4", {tag, " mark/clear write order"}, wr_q.size(), 2 * exp_n);
    @(negedge clk);
    capture = 1'b0;
    chk(!done && !busy, "R9", {tag, " pulse ends"}, {done, busy}, 0);
    repeat (2) @(negedge clk);
    chk(total_words == 32'(exp_total), "R9", {tag, " total held"}, total_words, exp_total);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base, w, len;
    logic [23:0] link;
    rst_n = 1'b0; start = 1'b0; start_addr = '0;
    fill_bg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && !mem_rd && !mem_wr && total_words == 0,
        "R10", "reset state", {busy, done, cmd_valid, mem_rd, mem_wr}, 0);

    // R1 R6 R8: sweep node counts and length patterns (includes empty nodes)
    for (int nn = 1; nn <= 5; nn++) begin
      for (int lp = 0; lp < 4; lp++) begin
        fill_bg();
        base = 8;
        for (int k = 0; k < nn; k++) begin
          w = base + k * 12;
          len = (lp == 3) ? 0 : (k + lp) % 4;
          link = (k == nn - 1) ? 24'hFFFFFF : 24'((base + (k + 1) * 12) * 4);
          set_hdr(w, len, link);
        end
        run(24'(base * 4), 1'b0, $sformatf("sweep n%0d p%0d", nn, lp));
      end
    end

    // R3: upper address bits ignored on start and links
    fill_bg();
    set_hdr(20, 2, 24'h600000 | 24'(40 * 4));
    set_hdr(40, 1, 24'hFFFFFF);
    run(24'h600000 | 24'(20 * 4), 1'b0, "R3 masked");

    // R5: self loop
    fill_bg();
    set_hdr(100, 2, 24'(100 * 4));
    run(24'(100 * 4), 1'b0, "R5 self loop");

    // R5: three-node ring back to first
    fill_bg();
    set_hdr(200, 1, 24'(210 * 4));
    set_hdr(210, 0, 24'(220 * 4));
    set_hdr(220, 3, 24'(200 * 4));
    run(24'(200 * 4), 1'b0, "R5 ring");

    // R2: link with bit 23 already set stops the walk
    fill_bg();
    set_hdr(300, 2, 24'h800000 | 24'(310 * 4));
    set_hdr(310, 1, 24'hFFFFFF);
    run(24'(300 * 4), 1'b0, "R2 preset mark");

    // R2: terminator as start address
    fill_bg();
    run(24'hFFFFFF, 1'b0, "R2 empty start");

    // R10: start while busy ignored; R1: full-width count
    fill_bg();
    set_hdr(500, 255, 24'(4 * 4));
    set_hdr(4, 1, 24'hFFFFFF);
    run(24'(500 * 4), 1'b1, "R10 restart ignored");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule